// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with Thresholds and Flush

The block sits between a register-bus agent and a serial shift engine. It holds two queues of 32-bit entries, each 8 entries deep by default. The transmit queue is filled from the bus and drained by the engine. The receive queue is filled by the engine and drained by the bus. Every entry carries its data word together with a count of valid bytes. When a word is written into the transmit queue, the byte lanes above that count are filled with all ones. When a word is written into the receive queue, those lanes are cleared to zero. A word-size input picks the entry size: single-byte entries, or entries of up to four bytes.

Software watches a 12-bit status vector. The vector holds full and empty bits for each queue, and a ready bit for each queue that follows a programmable threshold. It also holds sticky overflow and underflow bits for each queue. A push into a full queue is dropped. A pop from an empty queue returns zero. Both events are recorded in the sticky bits. A one-cycle flush request sets a self-clearing busy bit. On the next cycle both queues are emptied and all sticky bits are cleared.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After reset both queues are empty, `flush_busy` is 0, and no sticky bit is set. With both thresholds at 3, `status` reads 12'h058. In the empty state the data outputs are 0.
- R2: Each queue returns its entries in the order they were accepted, with the data and the valid-byte count of each entry intact.
- R3: A push into a full queue is dropped and leaves the stored contents unchanged. It sets the overflow bit: `status[11]` for transmit, `status[9]` for receive. The bit then stays set.
- R4: A pop from an empty queue returns data 0. It sets the underflow bit: `status[10]` for transmit, `status[8]` for receive. The bit then stays set.
- R5: The full bits are `status[7]` (transmit) and `status[5]` (receive). The empty bits are `status[6]` (transmit) and `status[4]` (receive). Each bit follows the entry count of its queue after every accepted push or pop.
- R6: `status[2]` (receive ready) is 1 exactly when the receive queue holds more entries than `rd_thresh`.
- R7: `status[3]` (transmit ready) is 1 exactly when the transmit queue has more free entries than `wr_thresh`.
- R8: When `flush_set` is high at a clock edge, `flush_busy` is 1 for the following cycle. At the edge after that, both queues become empty and all four sticky bits clear. Any push or pop during the busy cycle is ignored. `flush_busy` then returns to 0 by itself.
- R9: A transmit push with word mode set (`word_mode`=1) keeps byte lanes 0 through `bus_tx_nbytes`, where that field is the byte count minus one, and fills the higher lanes with 8'hFF. With `word_mode`=0, only lane 0 is kept and the stored count is 0.
- R10: A receive push keeps byte lanes 0 through `eng_rx_nbytes` when `word_mode`=1 and clears the higher lanes to 0. With `word_mode`=0, only lane 0 is kept and the stored count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_mode | input | 1 | 1: entries of up to 4 bytes; 0: single-byte entries |
| rd_thresh | input | 3 | Receive ready threshold |
| wr_thresh | input | 3 | Transmit ready threshold |
| flush_set | input | 1 | Request to flush both queues |
| flush_busy | output | 1 | Self-clearing flush bit |
| bus_tx_push | input | 1 | Bus writes one transmit entry |
| bus_tx_data | input | 32 | Transmit data from the bus |
| bus_tx_nbytes | input | 2 | Valid bytes minus one for the transmit push |
| eng_tx_pop | input | 1 | Engine takes one transmit entry |
| eng_tx_data | output | 32 | Head transmit entry, or 0 when empty |
| eng_tx_nbytes | output | 2 | Valid bytes minus one of the head transmit entry |
| eng_rx_push | input | 1 | Engine writes one receive entry |
| eng_rx_data | input | 32 | Receive data from the engine |
| eng_rx_nbytes | input | 2 | Valid bytes minus one for the receive push |
| bus_rx_pop | input | 1 | Bus takes one receive entry |
| bus_rx_data | output | 32 | Head receive entry, or 0 when empty |
| bus_rx_nbytes | output | 2 | Valid bytes minus one of the head receive entry |
| status | output | 12 | Status vector; bits 1:0 read 0 |

## Verification
Some properties are checked on every cycle:
- Each queue's count stays within its depth.
- A queue is never full and empty at once.
- The sticky bits hold until a flush.
- A ready bit is never set on a full transmit queue or an empty receive queue.
- A dropped push leaves the count unchanged.
- The flush bit clears itself and leaves both queues empty.

Other behaviour can only be shown by the bench's scenarios:
- The exact threshold crossing points.
- The lane padding and masking for each byte count and word mode.
- Entry ordering.
- The fact that an overflowing push does not disturb stored data.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
    localparam int STATUS_W  = 12;
    localparam int ST_TX_OVF = 11;
    localparam int ST_TX_UNF = 10;
    localparam int ST_RX_OVF = 9;
    localparam int ST_RX_UNF = 8;
    localparam int ST_TX_FUL = 7;
    localparam int ST_TX_EMP = 6;
    localparam int ST_RX_FUL = 5;
    localparam int ST_RX_EMP = 4;
    localparam int ST_TX_RDY = 3;
    localparam int ST_RX_RDY = 2;
endpackage

// File: rtl/xfp_lane_fmt.sv
module xfp_lane_fmt #(
    parameter int       BYTES = 4,
    parameter logic [7:0] FILL = 8'hFF,
    localparam int      CW    = $clog2(BYTES)
) (
    input  logic               word_mode,
    input  logic [8*BYTES-1:0] data_i,
    input  logic [CW-1:0]      nbytes_i,
    output logic [8*BYTES-1:0] data_o,
    output logic [CW-1:0]      nbytes_o
);
    assign nbytes_o = word_mode ? nbytes_i : '0;

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign data_o[8*i +: 8] = (CW'(i) <= nbytes_o) ? data_i[8*i +: 8] : FILL;
    end
endmodule

// File: rtl/xfp_fifo_core.sv
module xfp_fifo_core #(
    parameter int W     = 34,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push,
    input  logic [W-1:0]    push_data,
    input  logic            pop,
    output logic [W-1:0]    pop_data,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            empty,
    output logic            ovf,
    output logic            unf
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CNTW-1:0]         cnt;
        logic                    ovf;
        logic                    unf;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        logic is_full, is_empty, do_push, do_pop;
        st_d     = st_q;
        is_full  = (st_q.cnt == CNTW'(DEPTH));
        is_empty = (st_q.cnt == '0);
        do_push  = push && !is_full;
        do_pop   = pop && !is_empty;
        if (clear) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
            st_d.unf = 1'b0;
        end else begin
            if (push && is_full) st_d.ovf = 1'b1;
            if (pop && is_empty) st_d.unf = 1'b1;
            if (do_push) begin
                st_d.mem[st_q.wp] = push_data;
                st_d.wp           = bump(st_q.wp);
            end
            if (do_pop) st_d.rp = bump(st_q.rp);
            st_d.cnt = st_q.cnt + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full     = (st_q.cnt == CNTW'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign count    = st_q.cnt;
    assign ovf      = st_q.ovf;
    assign unf      = st_q.unf;
    assign pop_data = empty ? '0 : st_q.mem[st_q.rp];

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNTW'(DEPTH));
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf && !clear |=> st_q.ovf);
    assert_unf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unf && !clear |=> st_q.unf);
    assert_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !clear |=> full && ovf);
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push && !clear |=> empty && unf);
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int BYTES = DATA_W / 8,
    localparam int CW    = $clog2(BYTES),
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1),
    localparam int TX_W  = DATA_W + CW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         word_mode,
    input  logic [THR_W-1:0]             rd_thresh,
    input  logic [THR_W-1:0]             wr_thresh,
    input  logic                         flush_set,
    output logic                         flush_busy,
    input  logic                         bus_tx_push,
    input  logic [DATA_W-1:0]            bus_tx_data,
    input  logic [CW-1:0]                bus_tx_nbytes,
    input  logic                         eng_tx_pop,
    output logic [DATA_W-1:0]            eng_tx_data,
    output logic [CW-1:0]                eng_tx_nbytes,
    input  logic                         eng_rx_push,
    input  logic [DATA_W-1:0]            eng_rx_data,
    input  logic [CW-1:0]                eng_rx_nbytes,
    input  logic                         bus_rx_pop,
    output logic [DATA_W-1:0]            bus_rx_data,
    output logic [CW-1:0]                bus_rx_nbytes,
    output logic [xfp_pkg::STATUS_W-1:0] status
);
    import xfp_pkg::*;

    typedef struct packed {
        logic flush;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.flush = flush_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign flush_busy = ctl_q.flush;

    logic [DATA_W-1:0] tx_fmt_data, rx_fmt_data;
    logic [CW-1:0]     tx_fmt_nb, rx_fmt_nb;

    xfp_lane_fmt #(.BYTES(BYTES), .FILL(8'hFF)) u_tx_fmt (
        .word_mode(word_mode), .data_i(bus_tx_data), .nbytes_i(bus_tx_nbytes),
        .data_o(tx_fmt_data), .nbytes_o(tx_fmt_nb));

    xfp_lane_fmt #(.BYTES(BYTES), .FILL(8'h00)) u_rx_fmt (
        .word_mode(word_mode), .data_i(eng_rx_data), .nbytes_i(eng_rx_nbytes),
        .data_o(rx_fmt_data), .nbytes_o(rx_fmt_nb));

    logic [TX_W-1:0] tx_head, rx_head;
    logic [CNTW-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_empty, tx_ovf, tx_unf;
    logic rx_full, rx_empty, rx_ovf, rx_unf;

    xfp_fifo_core #(.W(TX_W), .DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .clear(ctl_q.flush),
        .push(bus_tx_push), .push_data({tx_fmt_nb, tx_fmt_data}),
        .pop(eng_tx_pop), .pop_data(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty), .ovf(tx_ovf), .unf(tx_unf));

    xfp_fifo_core #(.W(TX_W), .DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .clear(ctl_q.flush),
        .push(eng_rx_push), .push_data({rx_fmt_nb, rx_fmt_data}),
        .pop(bus_rx_pop), .pop_data(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty), .ovf(rx_ovf), .unf(rx_unf));

    assign {eng_tx_nbytes, eng_tx_data} = tx_head;
    assign {bus_rx_nbytes, bus_rx_data} = rx_head;

    logic [CNTW-1:0] tx_free;
    logic            tx_rdy, rx_rdy;

    assign tx_free = CNTW'(DEPTH) - tx_cnt;
    assign tx_rdy  = tx_free > CNTW'(wr_thresh);
    assign rx_rdy  = rx_cnt > CNTW'(rd_thresh);

    always_comb begin
        status            = '0;
        status[ST_TX_OVF] = tx_ovf;
        status[ST_TX_UNF] = tx_unf;
        status[ST_RX_OVF] = rx_ovf;
        status[ST_RX_UNF] = rx_unf;
        status[ST_TX_FUL] = tx_full;
        status[ST_TX_EMP] = tx_empty;
        status[ST_RX_FUL] = rx_full;
        status[ST_RX_EMP] = rx_empty;
        status[ST_TX_RDY] = tx_rdy;
        status[ST_RX_RDY] = rx_rdy;
    end

    assert_flush_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy && !flush_set |=> !flush_busy);
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> status[ST_TX_EMP] && status[ST_RX_EMP]
                       && !status[ST_TX_OVF] && !status[ST_RX_UNF]);
    assert_full_empty_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[ST_TX_FUL] && status[ST_TX_EMP]) && !(status[ST_RX_FUL] && status[ST_RX_EMP]));
    assert_rx_rdy_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RX_RDY] |-> !status[ST_RX_EMP]);
    assert_tx_rdy_notfull_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_TX_RDY] |-> !status[ST_TX_FUL]);
    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_TX_EMP] |-> eng_tx_data == '0);
endmodule

// File: tb/sim_xfer_fifo_pair.sv
module sim_xfer_fifo_pair;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b1;
    logic [2:0]  rd_thresh = 3'd3;
    logic [2:0]  wr_thresh = 3'd3;
    logic        flush_set = 1'b0;
    logic        flush_busy;
    logic        bus_tx_push = 1'b0;
    logic [31:0] bus_tx_data = '0;
    logic [1:0]  bus_tx_nbytes = '0;
    logic        eng_tx_pop = 1'b0;
    logic [31:0] eng_tx_data;
    logic [1:0]  eng_tx_nbytes;
    logic        eng_rx_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic [1:0]  eng_rx_nbytes = '0;
    logic        bus_rx_pop = 1'b0;
    logic [31:0] bus_rx_data;
    logic [1:0]  bus_rx_nbytes;
    logic [11:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_fifo_pair u0 (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
        .rd_thresh(rd_thresh), .wr_thresh(wr_thresh),
        .flush_set(flush_set), .flush_busy(flush_busy),
        .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data), .bus_tx_nbytes(bus_tx_nbytes),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_nbytes(eng_tx_nbytes),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_nbytes(eng_rx_nbytes),
        .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data), .bus_rx_nbytes(bus_rx_nbytes),
        .status(status));

    // {word_mode, nbytes, input word, expected stored word}
    typedef struct packed {
        logic        wm;
        logic [1:0]  nb;
        logic [31:0] din;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t TX_VEC [6] = '{
        '{1'b1, 2'd3, 32'h12345678, 32'h12345678},
        '{1'b1, 2'd2, 32'hA1B2C3D4, 32'hFFB2C3D4},
        '{1'b1, 2'd1, 32'h55667788, 32'hFFFF7788},
        '{1'b1, 2'd0, 32'h11223344, 32'hFFFFFF44},
        '{1'b0, 2'd3, 32'hDEADBEEF, 32'hFFFFFFEF},
        '{1'b0, 2'd0, 32'h01020304, 32'hFFFFFF04}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic tx_push(input logic [31:0] d, input logic [1:0] nb);
        bus_tx_push = 1'b1; bus_tx_data = d; bus_tx_nbytes = nb;
        tick();
        bus_tx_push = 1'b0;
    endtask

    task automatic rx_push(input logic [31:0] d, input logic [1:0] nb);
        eng_rx_push = 1'b1; eng_rx_data = d; eng_rx_nbytes = nb;
        tick();
        eng_rx_push = 1'b0;
    endtask

    task automatic tx_pop(output logic [31:0] d, output logic [1:0] nb);
        d = eng_tx_data; nb = eng_tx_nbytes;
        eng_tx_pop = 1'b1;
        tick();
        eng_tx_pop = 1'b0;
    endtask

    task automatic rx_pop(output logic [31:0] d, output logic [1:0] nb);
        d = bus_rx_data; nb = bus_rx_nbytes;
        bus_rx_pop = 1'b1;
        tick();
        bus_rx_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [1:0]  nb;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 status", {20'd0, status}, 32'h058);
        chk("R1 flush_busy", {31'd0, flush_busy}, 32'd0);
        chk("R1 tx data empty", eng_tx_data, 32'd0);
        chk("R1 rx data empty", bus_rx_data, 32'd0);

        // R9: transmit lane padding table
        foreach (TX_VEC[i]) begin
            word_mode = TX_VEC[i].wm;
            tx_push(TX_VEC[i].din, TX_VEC[i].nb);
            tx_pop(d, nb);
            chk("R9 tx pad data", d, TX_VEC[i].exp);
            chk("R9 tx nbytes", {30'd0, nb}, {30'd0, TX_VEC[i].wm ? TX_VEC[i].nb : 2'd0});
        end
        word_mode = 1'b1;

        // R2, R10: receive order and lane masking
        rx_push(32'hAABBCCDD, 2'd3);
        rx_push(32'h11223344, 2'd1);
        word_mode = 1'b0;
        rx_push(32'hCAFEF00D, 2'd3);
        word_mode = 1'b1;
        rx_pop(d, nb);
        chk("R2 rx first", d, 32'hAABBCCDD);
        chk("R2 rx first nbytes", {30'd0, nb}, 32'd3);
        rx_pop(d, nb);
        chk("R10 rx mask word", d, 32'h00003344);
        rx_pop(d, nb);
        chk("R10 rx byte mode", d, 32'h0000000D);
        chk("R10 rx byte nbytes", {30'd0, nb}, 32'd0);

        // R6: receive ready threshold 3
        for (int k = 0; k < 3; k++) rx_push(32'h100 + k, 2'd3);
        chk("R6 rx rdy at 3", {31'd0, status[2]}, 32'd0);
        rx_push(32'h103, 2'd3);
        chk("R6 rx rdy at 4", {31'd0, status[2]}, 32'd1);
        for (int k = 4; k < 8; k++) rx_push(32'h100 + k, 2'd3);
        chk("R5 rx full", {31'd0, status[5]}, 32'd1);
        chk("R3 rx ovf clear", {31'd0, status[9]}, 32'd0);
        rx_push(32'hBAD0BAD0, 2'd3);
        chk("R3 rx ovf set", {31'd0, status[9]}, 32'd1);
        for (int k = 0; k < 8; k++) begin
            rx_pop(d, nb);
            chk("R2 rx order", d, 32'h100 + k);
        end
        chk("R5 rx empty", {31'd0, status[4]}, 32'd1);
        chk("R3 rx ovf sticky", {31'd0, status[9]}, 32'd1);

        // R7: transmit ready threshold 3
        for (int k = 0; k < 4; k++) tx_push(32'h200 + k, 2'd3);
        chk("R7 tx rdy free 4", {31'd0, status[3]}, 32'd1);
        tx_push(32'h204, 2'd3);
        chk("R7 tx rdy free 3", {31'd0, status[3]}, 32'd0);
        chk("R5 tx not empty", {31'd0, status[6]}, 32'd0);
        for (int k = 5; k < 8; k++) tx_push(32'h200 + k, 2'd3);
        chk("R5 tx full", {31'd0, status[7]}, 32'd1);
        tx_push(32'hDEAD0000, 2'd3);
        chk("R3 tx ovf set", {31'd0, status[11]}, 32'd1);
        for (int k = 0; k < 8; k++) begin
            tx_pop(d, nb);
            chk("R3 tx content intact", d, 32'h200 + k);
        end

        // R4: underflow
        chk("R4 tx empty data", eng_tx_data, 32'd0);
        tx_pop(d, nb);
        chk("R4 tx pop empty zero", d, 32'd0);
        chk("R4 tx unf set", {31'd0, status[10]}, 32'd1);
        rx_pop(d, nb);
        chk("R4 rx pop empty zero", d, 32'd0);
        chk("R4 rx unf set", {31'd0, status[8]}, 32'd1);
        tx_push(32'h5, 2'd3);
        rx_push(32'h6, 2'd3);
        chk("R4 tx unf sticky", {31'd0, status[10]}, 32'd1);

        // R8: flush
        flush_set = 1'b1;
        tick();
        flush_set = 1'b0;
        chk("R8 busy set", {31'd0, flush_busy}, 32'd1);
        bus_tx_push = 1'b1; bus_tx_data = 32'h77; bus_tx_nbytes = 2'd3;
        tick();
        bus_tx_push = 1'b0;
        chk("R8 busy cleared", {31'd0, flush_busy}, 32'd0);
        chk("R8 status after flush", {20'd0, status}, 32'h058);
        chk("R8 tx data after flush", eng_tx_data, 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule